// File: doc/BRIEF.md
# Event Counter Bank with Pair Ganging

This block is a bank of twelve 32-bit event counters for observing memory read and write traffic. A traffic source presents a flat vector of single-cycle event pulses, grouped as sources of sixteen event lines each. Every counter has a configuration word that selects one source and one event line. An enabled counter adds one on each clock edge where the selected line is high.

Software reaches the bank through a plain register bus: a write strobe, a word address, write data and a combinational read data port. Enables and interrupt enables are changed through separate set and clear registers. Overflows are latched per counter and combine into one interrupt line. The counter values are not mapped directly. Software writes an index to a select register and then reads or writes a shared count register. An odd counter can be chained to its even neighbour. In that mode it counts the neighbour's wraps, and the pair forms a 64-bit value with the odd counter as the upper word.

Every register write except a write to the unlock register is discarded until the unlock key has been written.

Top module: `evc_bank`

## Requirements
- R1: After reset every register reads zero, the bank is locked and `irq_o` is low.
- R2: Writes to any register other than the unlock register (0x1FC) are ignored unless the last write to that register was 0xC5ACCE55. Writing any other value locks the bank again.
- R3: A counter's configuration word (0x000 + 4*n) holds the event line in bits [3:0] and the source in bits [22:16]; other bits read zero. When enabled, the counter increments by one on each edge where `evt_i[source*16 + event]` is high. A source at or above the number of sources never counts.
- R4: Writing ones to 0x104 sets counter enables and writing ones to 0x108 clears them; bit n is counter n and both addresses read the enable mask. Interrupt enables behave the same way at 0x10C (set) and 0x110 (clear).
- R5: The select register (0x11C) keeps a 4-bit index in bits [3:0] and reads it back. The count register (0x120) reads the selected counter, and it reads zero when the index is 12 or above.
- R6: A count-register write loads the selected counter only while that counter is disabled. While the counter is enabled the write is ignored.
- R7: The gang register (0x118) keeps only odd bits. With bit k set, counter k ignores its own event and increments once each time counter k-1 wraps from all-ones to zero.
- R8: A counter's bit in the overflow register (0x114) sets when that counter wraps. Writing ones clears bits, and a wrap in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some counter has both its overflow bit and its interrupt enable set.
- R10: Global control (0x100) uses five bits: bit 0 run (counting happens only while it is set), bit 1 clear (while set, all counters and overflow bits are held at zero), and bits 2 to 4 stored flags for retrieval mode, capture and trigger override. The upper bits read zero.
- R11: Reads at unmapped or misaligned addresses return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | NUM_SRC*16 | Event pulses, line e of source s at bit s*16+e |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the bank with its default twelve 32-bit counters and reduces the event vector to four sources (64 lines). This keeps random source and event choices dense, so several counters often watch the same line. It also puts the configuration values that select a missing source within reach of a simple test. The counters stay at full width. Wraps, overflow latching and the carry into a ganged upper counter are reached by loading values close to all-ones while the counter is disabled. The bench then confirms that the chained upper counter ignores its own event line.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int SEL_W       = 4;
    localparam int EVT_W       = 4;
    localparam int SRC_W       = 7;
    localparam int EVT_PER_SRC = 1 << EVT_W;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

    localparam logic [ADDR_W-1:0] OFF_CFG    = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_EN_SET = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_IE_SET = 12'h10C;
    localparam logic [ADDR_W-1:0] OFF_IE_CLR = 12'h110;
    localparam logic [ADDR_W-1:0] OFF_OVF    = 12'h114;
    localparam logic [ADDR_W-1:0] OFF_GANG   = 12'h118;
    localparam logic [ADDR_W-1:0] OFF_SEL    = 12'h11C;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h120;
    localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'h1FC;

    // Global control, bit 0 is run
    typedef struct packed {
        logic trig_ovrd;
        logic capture;
        logic retrieve;
        logic clr;
        logic run;
    } gctl_t;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [EVT_W-1:0] evt;
    } cfg_t;

    function automatic cfg_t cfg_unpack(logic [DATA_W-1:0] w);
        cfg_t c;
        c.src = w[22:16];
        c.evt = w[3:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(cfg_t c);
        return {9'd0, c.src, 12'd0, c.evt};
    endfunction

    // Bits that may carry a gang link: odd positions below n
    function automatic logic [DATA_W-1:0] odd_mask(int n);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i % 2 == 1) && (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/evc_counter.sv
module evc_counter
    import evc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          cnt_en,
    input  logic                          upper,
    input  logic                          carry_in,
    input  cfg_t                          cfg,
    input  logic [NUM_SRC*EVT_PER_SRC-1:0] evt_i,
    input  logic                          load,
    input  logic [CNT_W-1:0]              load_val,
    output logic [CNT_W-1:0]              cnt_o,
    output logic                          wrap_o
);

    localparam int LINES = NUM_SRC * EVT_PER_SRC;
    localparam int IDX_W = $clog2(LINES);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] line_idx;
    logic             hit;
    logic             inc;

    always_comb begin
        line_idx = IDX_W'({cfg.src, cfg.evt});
        hit      = 1'b0;
        if (int'(cfg.src) < NUM_SRC) begin
            hit = evt_i[line_idx];
        end
    end

    assign inc    = cnt_en & (upper ? carry_in : hit);
    assign wrap_o = inc & (&cnt_q);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/evc_regs.sv
module evc_regs
    import evc_pkg::*;
#(
    parameter int NUM_CNT = 12,
    parameter int CNT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
    input  logic [NUM_CNT-1:0]            wrap_i,
    output cfg_t [NUM_CNT-1:0]            cfg_o,
    output gctl_t                         ctl_o,
    output logic [NUM_CNT-1:0]            en_o,
    output logic [NUM_CNT-1:0]            ie_o,
    output logic [NUM_CNT-1:0]            gang_o,
    output logic [NUM_CNT-1:0]            ovf_o,
    output logic [NUM_CNT-1:0]            load_o,
    output logic                          unlocked_o
);

    localparam logic [DATA_W-1:0] GANG_OK = odd_mask(NUM_CNT);

    cfg_t [NUM_CNT-1:0] cfg_q;
    gctl_t              ctl_q;
    logic [NUM_CNT-1:0] en_q, ie_q, gang_q, ovf_q;
    logic [NUM_CNT-1:0] en_n, ie_n, ovf_n;
    logic [SEL_W-1:0]   sel_q;
    logic               unlocked_q;
    logic               wr_ok;
    logic               sel_ok;
    logic [NUM_CNT-1:0] wmask;

    assign wr_ok  = bus_we && unlocked_q;
    assign sel_ok = int'(sel_q) < NUM_CNT;
    assign wmask  = bus_wdata[NUM_CNT-1:0];

    always_comb begin
        en_n  = en_q;
        ie_n  = ie_q;
        ovf_n = ovf_q;
        if (wr_ok && bus_addr == OFF_EN_SET) en_n  = en_n | wmask;
        if (wr_ok && bus_addr == OFF_EN_CLR) en_n  = en_n & ~wmask;
        if (wr_ok && bus_addr == OFF_IE_SET) ie_n  = ie_n | wmask;
        if (wr_ok && bus_addr == OFF_IE_CLR) ie_n  = ie_n & ~wmask;
        if (wr_ok && bus_addr == OFF_OVF)    ovf_n = ovf_n & ~wmask;
        ovf_n = ovf_n | wrap_i;
        if (ctl_q.clr) ovf_n = '0;
    end

    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            load_o[i] = wr_ok && (bus_addr == OFF_COUNT) && (int'(sel_q) == i) && !en_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            ctl_q      <= '0;
            en_q       <= '0;
            ie_q       <= '0;
            gang_q     <= '0;
            ovf_q      <= '0;
            sel_q      <= '0;
            unlocked_q <= 1'b0;
        end else begin
            if (bus_we && bus_addr == OFF_LOCK) begin
                unlocked_q <= (bus_wdata == UNLOCK_KEY);
            end
            if (wr_ok) begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (bus_addr == ADDR_W'(int'(OFF_CFG) + 4 * i)) begin
                        cfg_q[i] <= cfg_unpack(bus_wdata);
                    end
                end
                case (bus_addr)
                    OFF_CTRL: ctl_q  <= gctl_t'(bus_wdata[4:0]);
                    OFF_GANG: gang_q <= wmask & GANG_OK[NUM_CNT-1:0];
                    OFF_SEL:  sel_q  <= bus_wdata[SEL_W-1:0];
                    default: ;
                endcase
            end
            en_q  <= en_n;
            ie_q  <= ie_n;
            ovf_q <= ovf_n;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_addr == ADDR_W'(int'(OFF_CFG) + 4 * i)) begin
                bus_rdata = cfg_pack(cfg_q[i]);
            end
        end
        case (bus_addr)
            OFF_CTRL:               bus_rdata = DATA_W'(ctl_q);
            OFF_EN_SET, OFF_EN_CLR: bus_rdata = DATA_W'(en_q);
            OFF_IE_SET, OFF_IE_CLR: bus_rdata = DATA_W'(ie_q);
            OFF_OVF:                bus_rdata = DATA_W'(ovf_q);
            OFF_GANG:               bus_rdata = DATA_W'(gang_q);
            OFF_SEL:                bus_rdata = DATA_W'(sel_q);
            OFF_COUNT:              bus_rdata = sel_ok ? DATA_W'(cnt_i[sel_q]) : '0;
            default: ;
        endcase
    end

    assign cfg_o      = cfg_q;
    assign ctl_o      = ctl_q;
    assign en_o       = en_q;
    assign ie_o       = ie_q;
    assign gang_o     = gang_q;
    assign ovf_o      = ovf_q;
    assign unlocked_o = unlocked_q;

endmodule

// File: rtl/evc_bank.sv
module evc_bank
    import evc_pkg::*;
#(
    parameter int NUM_CNT = 12,
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 24
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_SRC*EVT_PER_SRC-1:0] evt_i,
    output logic                           irq_o
);

    cfg_t [NUM_CNT-1:0]            cfg_w;
    gctl_t                         ctl_w;
    logic [NUM_CNT-1:0]            en_w, ie_w, gang_w, ovf_w, load_w, wrap_w;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_w;
    logic                          unlocked_w;

    evc_regs #(
        .NUM_CNT(NUM_CNT),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_i     (cnt_w),
        .wrap_i    (wrap_w),
        .cfg_o     (cfg_w),
        .ctl_o     (ctl_w),
        .en_o      (en_w),
        .ie_o      (ie_w),
        .gang_o    (gang_w),
        .ovf_o     (ovf_w),
        .load_o    (load_w),
        .unlocked_o(unlocked_w)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic upper;
        logic carry;
        if (i % 2 == 1) begin : g_odd
            assign upper = gang_w[i];
            assign carry = wrap_w[i-1];
        end else begin : g_even
            assign upper = 1'b0;
            assign carry = 1'b0;
        end

        evc_counter #(
            .CNT_W  (CNT_W),
            .NUM_SRC(NUM_SRC)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clr     (ctl_w.clr),
            .cnt_en  (ctl_w.run & en_w[i]),
            .upper   (upper),
            .carry_in(carry),
            .cfg     (cfg_w[i]),
            .evt_i   (evt_i),
            .load    (load_w[i]),
            .load_val(bus_wdata[CNT_W-1:0]),
            .cnt_o   (cnt_w[i]),
            .wrap_o  (wrap_w[i])
        );
    end

    assign irq_o = |(ovf_w & ie_w);

endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
    import evc_pkg::*;
#(
    parameter int NUM_CNT = 12,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          unlocked,
    input logic [NUM_CNT-1:0]            en,
    input logic [NUM_CNT-1:0]            ie,
    input logic [NUM_CNT-1:0]            gang,
    input logic [NUM_CNT-1:0]            ovf,
    input logic                          clr,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    input logic                          irq_o
);

    // R2: a locked bank keeps its masks
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !(bus_we && bus_addr == OFF_LOCK)) |=>
            ($stable(en) && $stable(ie) && $stable(gang)));

    // R9: interrupt needs at least one interrupt enable
    assert_irq_needs_ie_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|ie));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        // R6: an enabled counter is never loaded, it only holds or steps by one
        assert_no_load_when_on_R6: assert property (@(posedge clk) disable iff (rst)
            (en[i] && !clr) |=>
                (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + CNT_W'(1)));

        // R8: leaving all-ones while enabled latches the overflow bit
        assert_wrap_flags_R8: assert property (@(posedge clk) disable iff (rst)
            (en[i] && !clr && (&cnt[i])) |=> ((&cnt[i]) || ovf[i]));

        if (i % 2 == 1) begin : g_pair
            // R7: a ganged upper counter moves only when its lower one wraps
            assert_upper_on_carry_R7: assert property (@(posedge clk) disable iff (rst)
                (gang[i] && en[i] && !clr) |=>
                    (cnt[i] == $past(cnt[i]) ||
                     ($past(&cnt[i-1]) && cnt[i-1] == '0)));
        end
    end

endmodule

bind evc_bank evc_bank_chk #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .unlocked(unlocked_w),
    .en      (en_w),
    .ie      (ie_w),
    .gang    (gang_w),
    .ovf     (ovf_w),
    .clr     (ctl_w.clr),
    .cnt     (cnt_w),
    .irq_o   (irq_o)
);

// File: tb/evc_bank_tb.sv
module evc_bank_tb;
    import evc_pkg::*;

    localparam int NCNT = 12;
    localparam int CW   = 32;
    localparam int NSRC = 4;
    localparam int EW   = NSRC * 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [EW-1:0] evt = '0;
    logic          irq;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    evc_bank #(.NUM_CNT(NCNT), .CNT_W(CW), .NUM_SRC(NSRC)) u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt), .irq_o(irq)
    );

    function automatic logic [31:0] exp_cfg(logic [31:0] w);
        return w & 32'h007F_000F;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rdcnt(int i, output logic [31:0] d);
        wr(OFF_SEL, 32'(i));
        rd(OFF_COUNT, d);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog got=hung exp=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] expc [3];
        int          idx  [3];
        int          line [3];
        int          seed;
        seed = $urandom(32'd1234);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(OFF_EN_SET, d); chk("R1 enable mask", d, 0);
        rd(OFF_CTRL, d);   chk("R1 control", d, 0);
        rd(OFF_COUNT, d);  chk("R1 counter0", d, 0);
        #1 chk("R1 irq", 32'(irq), 0);

        // R2 lock
        wr(OFF_EN_SET, 32'h3);
        rd(OFF_EN_SET, d); chk("R2 locked write ignored", d, 0);
        wr(OFF_LOCK, UNLOCK_KEY);
        wr(OFF_EN_SET, 32'h3);
        rd(OFF_EN_SET, d); chk("R2 unlocked write", d, 32'h3);
        wr(OFF_LOCK, 32'h0);
        wr(OFF_EN_CLR, 32'h3);
        rd(OFF_EN_SET, d); chk("R2 relocked", d, 32'h3);
        wr(OFF_LOCK, UNLOCK_KEY);

        // R4 set/clear
        wr(OFF_EN_CLR, 32'h1);
        rd(OFF_EN_CLR, d); chk("R4 enable clear readback", d, 32'h2);
        wr(OFF_EN_CLR, 32'hFFFF_FFFF);
        wr(OFF_IE_SET, 32'h0000_0A05);
        wr(OFF_IE_CLR, 32'h0000_0004);
        rd(OFF_IE_SET, d); chk("R4 irq enable mask", d, 32'h0000_0A01);
        wr(OFF_IE_CLR, 32'hFFFF_FFFF);

        // R3 configuration fields
        wr(OFF_CFG + 12'd4, 32'hFFFF_FFFF);
        rd(OFF_CFG + 12'd4, d); chk("R3 config fields", d, 32'h007F_000F);

        // R3 missing source never counts
        wr(OFF_CTRL, 32'h1);
        wr(OFF_EN_SET, 32'h2);
        @(negedge clk); evt = '1;
        repeat (5) @(negedge clk);
        evt = '0;
        wr(OFF_EN_CLR, 32'h2);
        rdcnt(1, d); chk("R3 absent source", d, 0);

        // R5 select
        wr(OFF_SEL, 32'hFFFF_FFF7);
        rd(OFF_SEL, d); chk("R5 select readback", d, 32'h7);
        wr(OFF_SEL, 32'd13);
        wr(OFF_COUNT, 32'h55);
        rd(OFF_COUNT, d); chk("R5 select out of range", d, 0);

        // R6 load only while disabled
        wr(OFF_SEL, 32'd3);
        wr(OFF_COUNT, 32'h1234);
        rd(OFF_COUNT, d); chk("R6 load when disabled", d, 32'h1234);
        wr(OFF_EN_SET, 32'h8);
        wr(OFF_COUNT, 32'h5555);
        rd(OFF_COUNT, d); chk("R6 load ignored when enabled", d, 32'h1234);
        wr(OFF_EN_CLR, 32'h8);

        // R3 random counting
        idx[0] = 0; idx[1] = 2; idx[2] = 5;
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 3; j++) begin
                logic [31:0] s, e;
                s = $urandom % NSRC;
                e = $urandom % 16;
                line[j] = int'(s) * 16 + int'(e);
                wr(OFF_CFG + 12'(4 * idx[j]), (s << 16) | e | 32'hFF80_FFF0);
                rd(OFF_CFG + 12'(4 * idx[j]), d);
                chk("R3 config random", d, exp_cfg((s << 16) | e | 32'hFF80_FFF0));
                expc[j] = $urandom & 32'hFFFF;
                wr(OFF_SEL, 32'(idx[j]));
                wr(OFF_COUNT, expc[j]);
            end
            wr(OFF_EN_SET, 32'h25);
            for (int c = 0; c < 150; c++) begin
                @(negedge clk);
                evt = {$urandom, $urandom} & ((r == 2) ? {$urandom, $urandom} : '1);
                for (int j = 0; j < 3; j++) expc[j] += 32'(evt[line[j]]);
            end
            @(negedge clk); evt = '0;
            wr(OFF_EN_CLR, 32'h25);
            for (int j = 0; j < 3; j++) begin
                rdcnt(idx[j], d); chk("R3 random count", d, expc[j]);
            end
        end

        // R7 R8 R9 ganging and overflow
        wr(OFF_EN_CLR, 32'hFFF);
        wr(OFF_GANG, 32'hFFFF_FFFF);
        rd(OFF_GANG, d); chk("R7 gang odd bits only", d, 32'hAAA);
        wr(OFF_GANG, 32'h2);
        wr(OFF_CFG, (32'd1 << 16) | 32'd2);
        wr(OFF_CFG + 12'd4, (32'd1 << 16) | 32'd2);
        wr(OFF_SEL, 0); wr(OFF_COUNT, 32'hFFFF_FFFE);
        wr(OFF_SEL, 1); wr(OFF_COUNT, 32'd5);
        wr(OFF_OVF, 32'hFFF);
        wr(OFF_IE_SET, 32'h1);
        wr(OFF_EN_SET, 32'h3);
        @(negedge clk); evt[18] = 1'b1;
        repeat (3) @(negedge clk);
        evt = '0;
        wr(OFF_EN_CLR, 32'h3);
        rdcnt(0, d); chk("R7 lower after wrap", d, 32'h1);
        rdcnt(1, d); chk("R7 upper counts carry only", d, 32'h6);
        rd(OFF_OVF, d); chk("R8 overflow latched", d, 32'h1);
        #1 chk("R9 irq raised", 32'(irq), 1);
        wr(OFF_IE_CLR, 32'h1);
        #1 chk("R9 irq masked", 32'(irq), 0);
        wr(OFF_IE_SET, 32'h1);
        wr(OFF_OVF, 32'h1);
        rd(OFF_OVF, d); chk("R8 overflow cleared", d, 0);
        #1 chk("R9 irq after clear", 32'(irq), 0);

        // R10 global control
        wr(OFF_CTRL, 32'h0);
        wr(OFF_EN_SET, 32'h1);
        @(negedge clk); evt[18] = 1'b1;
        repeat (4) @(negedge clk);
        evt = '0;
        rdcnt(0, d); chk("R10 run off holds", d, 32'h1);
        wr(OFF_CTRL, 32'hFFFF_FFFF);
        rd(OFF_CTRL, d); chk("R10 control readback", d, 32'h1F);
        rdcnt(1, d); chk("R10 clear counters", d, 0);
        wr(OFF_CTRL, 32'h1C);
        rd(OFF_CTRL, d); chk("R10 flags kept", d, 32'h1C);

        // R11 unmapped
        wr(12'h080, 32'hFFFF_FFFF);
        wr(12'h106, 32'hFFFF_FFFF);
        rd(12'h080, d); chk("R11 unmapped read", d, 0);
        rd(12'h106, d); chk("R11 misaligned read", d, 0);
        rd(OFF_EN_SET, d); chk("R11 write ignored", d, 32'h1);

        done = 1;
        report();
        $finish;
    end

endmodule